// File: doc/BRIEF.md
# External PWM phase spreader

This block sits between an externally supplied PWM dimming signal and sixteen LED string enables. It measures how far apart the rising edges of the dimming input are, counting cycles of a fast system clock. From that period it takes a delay step of one sixteenth. Each string enable then replays the input pulse, with the same high time, shifted later by its own index times that step. The strings therefore switch on one after another instead of all at once, and the supply sees a spread-out load.

Lane 0 never has a delay. The other lanes get a delay only after a trustworthy period measurement exists, and only while the external dimming mode is selected. In every other case all lanes copy the input with no delay. Each rising edge of the input starts a new period for every lane, so a delayed pulse that is still running when the next edge arrives is cut short there.

Top module: `pwm_phase_spreader`

## Requirements
- R1: While reset is high, and at the first sample after it, every bit of `str_en` is low.
- R2: `str_en[0]` always equals the value of `pwm_in` sampled at the previous clock edge.
- R3: Let P be the number of cycles between the two most recent rising edges of `pwm_in`, with P no larger than 65535 and `ext_mode` high at the later edge. For the period that starts at that later edge, lane k is high exactly where `pwm_in` was high k*floor(P/16) samples earlier within the same period. If P is below 16, no lane has a delay.
- R4: Within one period, each lane is high for as many cycles as `pwm_in` was high in that period, as long as the lane's delay plus that high time does not exceed the period. A change of duty takes effect in the same period.
- R5: At the first rising edge after reset there is no period measurement, so every lane copies `pwm_in` with no delay for that period.
- R6: When more than 65535 cycles pass between two rising edges, the measurement is invalid and the period that starts at the later edge has no delay on any lane. The next gap of 65535 cycles or fewer restores the spreading.
- R7: If `ext_mode` is low at a rising edge, every lane copies `pwm_in` with no delay for the period that starts there.
- R8: Every rising edge of `pwm_in` restarts all lanes. A lane whose new delay is nonzero goes low at that edge, even if its previous delayed pulse has not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the dimming input |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | High when dimming comes from the external PWM input, which enables spreading |
| pwm_in | input | 1 | External PWM dimming signal, synchronous to `clk` |
| str_en | output | 16 | Per-string enables; bit k carries the pulse delayed by k steps |

## Verification
The checks assume that `pwm_in` is already synchronous to `clk`, so the block samples it once per cycle and does no metastability filtering. They also assume that reset is asserted from time zero and that each period holds a single high run, which starts at the rising edge. The stimulus changes `pwm_in` and `ext_mode` only on the falling clock edge. Every pattern it sends is a well-formed pulse train with a high time of at least one cycle and shorter than its period, apart from one long low stretch that drives the period counter into overflow.

// File: rtl/pwmspread_pkg.sv
package pwmspread_pkg;

    // width of every cycle counter in the block
    localparam int CNT_W = 16;
    // number of string lanes the block drives
    localparam int LANES = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // sampled view of the dimming input
    typedef struct packed {
        logic rise;   // rising edge at this sample
        logic level;  // current sample value
    } edge_t;

    // result of the period measurement, valid at a rising edge
    typedef struct packed {
        logic ok;     // a spread period is in force
        cnt_t step;   // per-lane delay increment in cycles
    } meas_t;

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    // delay of one lane: its index times the step
    function automatic cnt_t lane_delay(int unsigned idx, cnt_t step);
        return cnt_t'(idx) * step;
    endfunction

endpackage

// File: rtl/pwmspread_edge.sv
module pwmspread_edge
    import pwmspread_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwm_in,
    output edge_t ev
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pwm_in;
        end
    end

    always_comb begin
        ev.level = pwm_in;
        ev.rise  = pwm_in & ~prev_q;
    end

endmodule

// File: rtl/pwmspread_meter.sv
module pwmspread_meter
    import pwmspread_pkg::*;
#(
    parameter int SHIFT = 4
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  logic  ext_mode,
    output meas_t meas
);

    cnt_t per_q;
    logic ovf_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= '0;
            ovf_q  <= 1'b0;
            seen_q <= 1'b0;
        end else if (rise) begin
            per_q  <= cnt_t'(1);
            ovf_q  <= 1'b0;
            seen_q <= 1'b1;
        end else if (per_q == '1) begin
            ovf_q  <= 1'b1;
        end else begin
            per_q  <= per_q + 1'b1;
        end
    end

    always_comb begin
        meas.ok   = seen_q & ~ovf_q & ext_mode;
        meas.step = meas.ok ? (per_q >> SHIFT) : '0;
    end

    // R6
    period_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise && per_q == '1 && seen_q) |=> !meas.ok);

endmodule

// File: rtl/pwmspread_tracker.sv
module pwmspread_tracker
    import pwmspread_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t ev,
    output cnt_t  highs_now
);

    cnt_t highs_q;

    // high samples seen in the current period, this sample included
    always_comb begin
        if (ev.rise) begin
            highs_now = cnt_t'(1);
        end else if (ev.level) begin
            highs_now = sat_inc(highs_q);
        end else begin
            highs_now = highs_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            highs_q <= '0;
        end else begin
            highs_q <= highs_now;
        end
    end

endmodule

// File: rtl/pwmspread_lane.sv
module pwmspread_lane
    import pwmspread_pkg::*;
#(
    parameter int IDX = 0
)(
    input  logic  clk,
    input  logic  rst,
    input  edge_t ev,
    input  cnt_t  step,
    input  cnt_t  highs_now,
    output logic  lane_on
);

    cnt_t dly_q, dly_n;
    cnt_t wid_q, wid_n;
    cnt_t load;
    logic on_n;

    assign load = lane_delay(IDX, step);

    always_comb begin
        dly_n = dly_q;
        wid_n = wid_q;
        on_n  = 1'b0;
        if (ev.rise) begin
            dly_n = load;
            on_n  = (load == '0);
            wid_n = on_n ? cnt_t'(1) : '0;
        end else begin
            if (dly_q != '0) begin
                dly_n = dly_q - 1'b1;
            end
            if (dly_n == '0) begin
                // replay while the input is still high or high samples are owed
                on_n = ev.level || (wid_q < highs_now);
                if (on_n) begin
                    wid_n = sat_inc(wid_q);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q   <= '0;
            wid_q   <= '0;
            lane_on <= 1'b0;
        end else begin
            dly_q   <= dly_n;
            wid_q   <= wid_n;
            lane_on <= on_n;
        end
    end

    // R4
    width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.rise |-> (wid_q <= highs_now));

endmodule

// File: rtl/pwm_phase_spreader.sv
module pwm_phase_spreader
    import pwmspread_pkg::*;
#(
    parameter int NUM_OUT = LANES
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_mode,
    input  logic               pwm_in,
    output logic [NUM_OUT-1:0] str_en
);

    localparam int SHIFT = $clog2(NUM_OUT);

    edge_t ev;
    meas_t meas;
    cnt_t  highs_now;

    pwmspread_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .ev     (ev)
    );

    pwmspread_meter #(.SHIFT(SHIFT)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .rise     (ev.rise),
        .ext_mode (ext_mode),
        .meas     (meas)
    );

    pwmspread_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .highs_now (highs_now)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        pwmspread_lane #(.IDX(k)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev),
            .step      (meas.step),
            .highs_now (highs_now),
            .lane_on   (str_en[k])
        );
    end

    // R2
    lane0_copy_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (str_en[0] == $past(pwm_in)));

    // R3
    spread_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && meas.ok && meas.step != '0) |=> (str_en[NUM_OUT-1:1] == '0));

    // R5
    no_meas_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !meas.ok) |=> (&str_en));

    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !ext_mode) |=> (&str_en));

endmodule

// File: tb/tb_pwm_phase_spreader.sv
module tb_pwm_phase_spreader;
    import pwmspread_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ext_mode = 1'b1;
    logic             pwm_in = 1'b0;
    logic [LANES-1:0] str_en;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // reference model state
    bit      m_prev = 0;
    bit      m_have = 0;
    longint  m_n = 0;
    longint  m_last = 0;
    int      m_dly[LANES];
    bit      m_per[$];

    always #5 clk = ~clk;

    pwm_phase_spreader dut (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .pwm_in   (pwm_in),
        .str_en   (str_en)
    );

    function automatic logic [LANES-1:0] model_step(bit x, bit e);
        logic [LANES-1:0] exp_v;
        int idx;
        longint gap;
        int stp;
        if (x && !m_prev) begin
            gap = m_n - m_last;
            if (m_have && gap <= 65535 && e) stp = int'(gap / LANES);
            else stp = 0;
            for (int k = 0; k < LANES; k++) m_dly[k] = k * stp;
            m_per.delete();
            m_have = 1;
            m_last = m_n;
        end
        if (m_have) m_per.push_back(x);
        exp_v = '0;
        if (m_have) begin
            idx = m_per.size() - 1;
            for (int k = 0; k < LANES; k++)
                if (idx >= m_dly[k]) exp_v[k] = m_per[idx - m_dly[k]];
        end
        m_prev = x;
        m_n++;
        return exp_v;
    endfunction

    task automatic tick(bit x, bit e, string tag);
        logic [LANES-1:0] exp_v;
        pwm_in   = x;
        ext_mode = e;
        @(posedge clk);
        exp_v = model_step(x, e);
        @(negedge clk);
        total++;
        if (str_en !== exp_v) begin
            bad++;
            $display("FAIL %s lanes cycle=%0d actual=%h expected=%h", tag, m_n - 1, str_en, exp_v);
        end
        total++;
        if (str_en[0] !== x) begin
            bad++;
            $display("FAIL R2 lane0 cycle=%0d actual=%b expected=%b", m_n - 1, str_en[0], x);
        end
    endtask

    task automatic pulses(int period, int high, int count, bit e, string tag);
        for (int c = 0; c < count; c++) begin
            for (int i = 0; i < period; i++) tick(i < high, e, tag);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (str_en !== '0) begin
            bad++;
            $display("FAIL R1 reset actual=%h expected=%h", str_en, {LANES{1'b0}});
        end
        rst = 1'b0;
        // R1: first sample after reset with input low
        tick(1'b0, 1'b1, "R1");
        // R5: first period has no measurement
        pulses(64, 20, 1, 1'b1, "R5");
        // R3: steady spreading, step 4
        pulses(64, 20, 3, 1'b1, "R3");
        // R4: step 10, last lane ends exactly at the period
        pulses(160, 10, 3, 1'b1, "R4");
        // R4: duty change and single-cycle pulses
        pulses(100, 1, 3, 1'b1, "R4");
        pulses(100, 37, 2, 1'b1, "R4");
        // R8: delayed pulses overrun the next rising edge
        pulses(160, 40, 3, 1'b1, "R8");
        // R3: period below 16 gives step zero
        pulses(10, 5, 4, 1'b1, "R3");
        pulses(48, 9, 2, 1'b1, "R3");
        // R7: mode off suppresses spreading, then restored
        pulses(64, 20, 2, 1'b0, "R7");
        pulses(64, 20, 2, 1'b1, "R7");
        // R6: gap longer than the counter range
        pulses(66000, 5, 1, 1'b1, "R6");
        pulses(64, 20, 3, 1'b1, "R6");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule